// File: doc/BRIEF.md
# General-Purpose Register Bank with Product Register Pair

This block is the integer register storage of a load/store RISC datapath. It keeps a bank of general-purpose registers, 32 of 32 bits by default. Two index fields of the instruction word select the two source operands, and the destination field selects the register to write. Entry zero is a constant zero: it reads as zero and takes no writes. Every other entry holds the last value written to it.

Both read ports are combinational. The single write port commits on the rising clock edge. When a port reads the entry that is being written in the same cycle, it returns the incoming value, so the datapath needs no separate forwarding path for this case. A parameter can turn this forwarding off.

Next to the bank sits a pair of wide-result registers, called upper and lower. A multiply/divide unit loads both at once from a double-width result through its own strobe. Move-from instructions read them on dedicated outputs. A synchronous reset clears the whole bank and both halves of the pair.

Top module: `regbank_hilo`

## Requirements
- R1: When `rst` is high at a rising edge, every entry, `hi_q` and `lo_q` read zero after that edge.
- R2: With `wr_en` high and a nonzero `wr_idx`, `wr_data` is stored at the rising edge, and later reads of that index return it until it is next written.
- R3: The two read ports are independent. Each returns the entry selected by its own index, including when both select the same entry.
- R4: Index 0 reads zero on both ports at all times, including while a write targets index 0.
- R5: A write to index 0 is discarded and leaves every other entry unchanged.
- R6: While `wr_en` is high and `wr_idx` is nonzero and equal to a port's read index, that port returns `wr_data` in the same cycle.
- R7: With `wr_en` low, no entry changes at the clock edge.
- R8: With `mdu_wr` high at a rising edge, `hi_q` takes bits [63:32] of `mdu_result` and `lo_q` takes bits [31:0], both at that one edge.
- R9: With `mdu_wr` low, `hi_q` and `lo_q` hold their values.
- R10: A bank write and a pair write in the same cycle both take effect without disturbing each other.
- R11: Reset takes priority over a bank write or a pair write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bank write enable |
| wr_idx | input | 5 | Destination index |
| wr_data | input | 32 | Value to write |
| rd_a_idx | input | 5 | First source index |
| rd_a_data | output | 32 | First source value |
| rd_b_idx | input | 5 | Second source index |
| rd_b_data | output | 32 | Second source value |
| mdu_wr | input | 1 | Pair load strobe |
| mdu_result | input | 64 | Double-width result, upper half to `hi_q` |
| hi_q | output | 32 | Upper product register |
| lo_q | output | 32 | Lower product register |

## Verification
A vector table writes distinct patterns to the lowest, highest and a middle index, then reads them back through both ports. This separates a working store from address aliasing and from ports that are swapped or tied together. Rows that write with the enable low, or that target index 0, show whether a discarded write is really ignored. Rows that overwrite an entry show whether it holds the latest value. Directed cases read an entry in the same cycle it is written, which separates a forwarding port from a plain one. They also drive pair loads with asymmetric halves, which exposes a swap of the upper and lower halves, and they assert reset together with writes to show that reset wins.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
   localparam int unsigned DEF_DATA_W   = 32;
   localparam int unsigned DEF_NUM_REGS = 32;

   typedef enum logic [0:0] {
      FWD_OFF = 1'b0,
      FWD_ON  = 1'b1
   } fwd_mode_e;
endpackage

// File: rtl/regbank_array.sv
module regbank_array #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_idx,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [NUM_REGS*DATA_W-1:0] bank_flat
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_entry
         if (gi == 0) begin : g_zero
            assign bank_flat[DATA_W-1:0] = '0;
         end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
               if (rst)
                  q <= '0;
               else if (wr_en && (wr_idx == ADDR_W'(gi)))
                  q <= wr_data;
            end
            assign bank_flat[gi*DATA_W +: DATA_W] = q;
         end
      end
   endgenerate
endmodule

// File: rtl/regbank_rdport.sv
module regbank_rdport
   import regbank_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned ADDR_W   = $clog2(NUM_REGS),
   parameter fwd_mode_e   FWD      = FWD_ON
) (
   input  logic [NUM_REGS*DATA_W-1:0] bank_flat,
   input  logic [ADDR_W-1:0]          rd_idx,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_idx,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [DATA_W-1:0]          rd_data
);
   logic [DATA_W-1:0] stored;

   always_comb begin
      stored = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_idx == ADDR_W'(i))
            stored = bank_flat[i*DATA_W +: DATA_W];
      end
   end

   generate
      if (FWD == FWD_ON) begin : g_fwd
         logic hit;
         assign hit     = wr_en && (wr_idx != '0) && (wr_idx == rd_idx);
         assign rd_data = hit ? wr_data : stored;
      end else begin : g_plain
         logic unused_w;
         assign unused_w = wr_en ^ (^wr_idx) ^ (^wr_data);
         assign rd_data  = stored;
      end
   endgenerate
endmodule

// File: rtl/regbank_hilo_pair.sv
module regbank_hilo_pair #(
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                mdu_wr,
   input  logic [2*DATA_W-1:0] mdu_result,
   output logic [DATA_W-1:0]   hi_q,
   output logic [DATA_W-1:0]   lo_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (mdu_wr) begin
         hi_q <= mdu_result[2*DATA_W-1:DATA_W];
         lo_q <= mdu_result[DATA_W-1:0];
      end
   end
endmodule

// File: rtl/regbank_hilo.sv
module regbank_hilo
   import regbank_pkg::*;
#(
   parameter int unsigned DATA_W   = DEF_DATA_W,
   parameter int unsigned NUM_REGS = DEF_NUM_REGS,
   parameter fwd_mode_e   FWD      = FWD_ON,
   localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
   localparam int unsigned WIDE_W  = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [ADDR_W-1:0] rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              mdu_wr,
   input  logic [WIDE_W-1:0] mdu_result,
   output logic [DATA_W-1:0] hi_q,
   output logic [DATA_W-1:0] lo_q
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("regbank_hilo: DATA_W must be at least 1");
      end
      if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_depth
         $error("regbank_hilo: NUM_REGS must be a power of two of at least 2");
      end
   endgenerate

   logic [NUM_REGS*DATA_W-1:0] bank_flat;

   regbank_array #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)
   ) u_array (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .bank_flat(bank_flat)
   );

   regbank_rdport #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .FWD(FWD)
   ) u_rd_a (
      .bank_flat(bank_flat), .rd_idx(rd_a_idx), .wr_en(wr_en),
      .wr_idx(wr_idx), .wr_data(wr_data), .rd_data(rd_a_data)
   );

   regbank_rdport #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .FWD(FWD)
   ) u_rd_b (
      .bank_flat(bank_flat), .rd_idx(rd_b_idx), .wr_en(wr_en),
      .wr_idx(wr_idx), .wr_data(wr_data), .rd_data(rd_b_data)
   );

   regbank_hilo_pair #(
      .DATA_W(DATA_W)
   ) u_pair (
      .clk(clk), .rst(rst), .mdu_wr(mdu_wr), .mdu_result(mdu_result),
      .hi_q(hi_q), .lo_q(lo_q)
   );
endmodule

// File: rtl/regbank_hilo_chk.sv
module regbank_hilo_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [ADDR_W-1:0] rd_b_idx,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              mdu_wr,
   input logic [2*DATA_W-1:0] mdu_result,
   input logic [DATA_W-1:0] hi_q,
   input logic [DATA_W-1:0] lo_q
);
   // R1 / R11: reset clears the product pair
   p_reset_clears_r1: assert property (@(posedge clk)
      rst |=> (hi_q == '0 && lo_q == '0));

   // R4: index 0 reads zero on both ports
   p_zero_a_r4: assert property (@(posedge clk) disable iff (rst)
      (rd_a_idx == '0) |-> (rd_a_data == '0));
   p_zero_b_r4: assert property (@(posedge clk) disable iff (rst)
      (rd_b_idx == '0) |-> (rd_b_data == '0));

   // R6: same-cycle forwarding on port A
   p_fwd_a_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx != '0 && rd_a_idx == wr_idx) |-> (rd_a_data == wr_data));

   // R2: a committed write is visible after the edge
   p_write_seen_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx != '0) |=>
         (rd_a_idx != $past(wr_idx) || (wr_en && wr_idx == rd_a_idx) ||
          rd_a_data == $past(wr_data)));

   // R8: pair load splits the wide result
   p_pair_load_r8: assert property (@(posedge clk) disable iff (rst)
      mdu_wr |=> (hi_q == $past(mdu_result[2*DATA_W-1:DATA_W]) &&
                  lo_q == $past(mdu_result[DATA_W-1:0])));

   // R9: pair holds without the strobe
   p_pair_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !mdu_wr |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind regbank_hilo regbank_hilo_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
   .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx),
   .rd_b_data(rd_b_data), .mdu_wr(mdu_wr), .mdu_result(mdu_result),
   .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/regbank_hilo_tb.sv
module regbank_hilo_tb;
   localparam int CLK_PERIOD = 10;
   localparam int VEC_W = 1 + 5 + 32 + 5 + 5 + 32 + 32;
   localparam int N_VEC = 8;

   // {we, widx, wdata, rd_a, rd_b, expect_a, expect_b}
   localparam logic [VEC_W-1:0] VECS [N_VEC] = '{
      {1'b1, 5'd5,  32'hA5A5_0001, 5'd5,  5'd0,  32'hA5A5_0001, 32'h0000_0000},
      {1'b1, 5'd0,  32'hFFFF_FFFF, 5'd0,  5'd5,  32'h0000_0000, 32'hA5A5_0001},
      {1'b1, 5'd31, 32'h8000_0000, 5'd31, 5'd5,  32'h8000_0000, 32'hA5A5_0001},
      {1'b0, 5'd5,  32'h1234_5678, 5'd5,  5'd31, 32'hA5A5_0001, 32'h8000_0000},
      {1'b1, 5'd5,  32'h0000_00FF, 5'd5,  5'd31, 32'h0000_00FF, 32'h8000_0000},
      {1'b1, 5'd1,  32'hDEAD_BEEF, 5'd1,  5'd1,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
      {1'b1, 5'd30, 32'h0000_0000, 5'd30, 5'd1,  32'h0000_0000, 32'hDEAD_BEEF},
      {1'b1, 5'd2,  32'h0000_0001, 5'd2,  5'd31, 32'h0000_0001, 32'h8000_0000}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  rd_a_idx = '0;
   logic [4:0]  rd_b_idx = '0;
   logic        mdu_wr = 1'b0;
   logic [63:0] mdu_result = '0;
   logic [31:0] rd_a_data, rd_b_data, hi_q, lo_q;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regbank_hilo u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx),
      .rd_b_data(rd_b_data), .mdu_wr(mdu_wr), .mdu_result(mdu_result),
      .hi_q(hi_q), .lo_q(lo_q)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      wr_en = 1'b0; mdu_wr = 1'b0; rst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state on every index
      for (int i = 0; i < 32; i++) begin
         rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i);
         #1;
         chk("R1 port A", rd_a_data, 32'h0);
         chk("R1 port B", rd_b_data, 32'h0);
      end
      chk("R1 hi", hi_q, 32'h0);
      chk("R1 lo", lo_q, 32'h0);

      // Table walk: R2 R3 R4 R5 R7
      for (int v = 0; v < N_VEC; v++) begin
         logic [VEC_W-1:0] row;
         row = VECS[v];
         @(negedge clk);
         wr_en   = row[VEC_W-1];
         wr_idx  = row[VEC_W-2 -: 5];
         wr_data = row[VEC_W-7 -: 32];
         @(negedge clk);
         wr_en    = 1'b0;
         rd_a_idx = row[73:69];
         rd_b_idx = row[68:64];
         #1;
         chk("R2/R3/R5/R7 table port A", rd_a_data, row[63:32]);
         chk("R2/R3/R5/R7 table port B", rd_b_data, row[31:0]);
      end

      // R6: same-cycle forwarding, before commit
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'd7; wr_data = 32'hCAFE_0007;
      rd_a_idx = 5'd7; rd_b_idx = 5'd7;
      #1;
      chk("R6 forward port A", rd_a_data, 32'hCAFE_0007);
      chk("R6 forward port B", rd_b_data, 32'hCAFE_0007);
      @(negedge clk);
      idle();
      #1;
      chk("R6 committed value", rd_a_data, 32'hCAFE_0007);

      // R4: index 0 during a write to index 0
      wr_en = 1'b1; wr_idx = 5'd0; wr_data = 32'h5555_5555;
      rd_a_idx = 5'd0; rd_b_idx = 5'd0;
      #1;
      chk("R4 zero port A", rd_a_data, 32'h0);
      chk("R4 zero port B", rd_b_data, 32'h0);
      @(negedge clk);
      idle();
      rd_b_idx = 5'd31;
      #1;
      chk("R5 other entry intact", rd_b_data, 32'h8000_0000);

      // R8: pair load, upper half to hi
      mdu_wr = 1'b1; mdu_result = 64'h1111_2222_3333_4444;
      #1;
      chk("R8 hi before edge", hi_q, 32'h0);
      @(negedge clk);
      mdu_wr = 1'b0; mdu_result = 64'h9999_8888_7777_6666;
      #1;
      chk("R8 hi", hi_q, 32'h1111_2222);
      chk("R8 lo", lo_q, 32'h3333_4444);

      // R9: strobe low, pair holds
      @(negedge clk);
      #1;
      chk("R9 hi hold", hi_q, 32'h1111_2222);
      chk("R9 lo hold", lo_q, 32'h3333_4444);

      // R10: simultaneous bank and pair writes
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'h0909_0909;
      mdu_wr = 1'b1; mdu_result = 64'hAAAA_0000_0000_BBBB;
      @(negedge clk);
      idle();
      rd_a_idx = 5'd9;
      #1;
      chk("R10 bank entry", rd_a_data, 32'h0909_0909);
      chk("R10 hi", hi_q, 32'hAAAA_0000);
      chk("R10 lo", lo_q, 32'h0000_BBBB);

      // R11: reset beats concurrent writes
      @(negedge clk);
      rst = 1'b1;
      wr_en = 1'b1; wr_idx = 5'd3; wr_data = 32'h3333_3333;
      mdu_wr = 1'b1; mdu_result = 64'hFFFF_FFFF_FFFF_FFFF;
      @(negedge clk);
      idle();
      rd_a_idx = 5'd3; rd_b_idx = 5'd31;
      #1;
      chk("R11 written entry cleared", rd_a_data, 32'h0);
      chk("R11 old entry cleared", rd_b_data, 32'h0);
      chk("R11 hi cleared", hi_q, 32'h0);
      chk("R11 lo cleared", lo_q, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule